// File: doc/BRIEF.md
# Clock Manager Reset Supervisor

This block sits beside an on-chip frequency synthesizer and decides when that synthesizer must be reset, and when logic clocked by its output may leave reset. In the reference clock domain it watches the lock flag and a status vector. When lock is lost, or when a status bit reports that the input or the output clock has stopped, it issues a short reset pulse to the synthesizer. It never re-issues a reset just because lock is slow to arrive, so a slow or jittery acquisition cannot be trapped in a retry loop.

A second, independent path produces the reset for logic in the synthesized domain. That reset is applied at once, without needing any clock, whenever lock is absent, the input clock is stopped or the external reset is pressed. It is removed only after the clear condition has passed through a release synchronizer and a fixed settling count of synthesized-clock cycles. The external reset from a button is treated as synchronous to the reference clock.

Top module: `clkmgr_rst_sup`

## Requirements
- R1: A falling lock flag causes a synthesizer reset pulse: when `lock_in` drops before reference edge A, `mgr_rst` is low after edges A and B and high after the third edge C (two synchronizer stages plus one pulse register).
- R2: Status bit 1 (input clock stopped) or status bit 2 (output clock stopped) of `stat_in` causes the same pulse with the same latency as R1; while either bit stays set, `mgr_rst` stays high.
- R3: A single trigger makes `mgr_rst` high for exactly 3 reference cycles (high after edges C, D, E and low after edge F).
- R4: While `ext_rst` is high, `mgr_rst` is high in the same time step; after `ext_rst` falls, `mgr_rst` stays high until the third reference edge and then drops, even if lock is low at release.
- R5: Lock staying low after a pulse never causes another pulse; no timer-driven retry exists.
- R6: A rising lock flag causes no synthesizer reset.
- R7: `dom_rst` rises in the same time step as `lock_in` falling, status bit 1 rising or `ext_rst` rising, with or without `syn_clk` running, and stays high while that condition holds.
- R8: Once lock is high, status bit 1 low and `ext_rst` low, `dom_rst` falls at the 10th rising edge of `syn_clk` (2 release stages plus 8 settling cycles) and not before; with no `syn_clk` it stays high.
- R9: A loss of lock during the settling count reasserts `dom_rst` at once and restarts the full count.
- R10: Status bit 2 (output clock stopped) has no effect on `dom_rst`.
- R11: Status bit 0 has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock fed to the synthesizer |
| ext_rst | input | 1 | External reset, active high, synchronous to `ref_clk` |
| lock_in | input | 1 | Lock flag from the synthesizer (asynchronous) |
| stat_in | input | STAT_W (3) | Synthesizer status: bit 1 input clock stopped, bit 2 output clock stopped, bit 0 unused |
| syn_clk | input | 1 | Synthesized clock driving downstream logic |
| mgr_rst | output | 1 | Reset to the synthesizer, active high |
| dom_rst | output | 1 | Reset for the synthesized-clock domain, active high |

## Verification
The bench targets the moment of release after the external reset with lock low: a design that treated the cleared lock history as a fresh loss would fire a spurious pulse there. It holds lock low for many cycles after a pulse, where a retry timer would reset a synthesizer that is still acquiring. It drops lock halfway through the settling count, where a design that paused instead of restarting would release early, and it stops the synthesized clock to show that the downstream reset is applied without it. Random lock and status traffic is compared against a cycle model of the pulse latency and length, which catches an off-by-one in the synchronizer depth or the pulse length.

// File: rtl/csup_pkg.sv
`timescale 1ns/1ps
package csup_pkg;

    // Smallest synchronizer depth the block accepts.
    localparam int unsigned SYNC_MIN = 2;

    // True when any bit selected by mask is set in vec.
    function automatic logic any_set(input logic [31:0] vec, input logic [31:0] mask);
        return |(vec & mask);
    endfunction

endpackage

// File: rtl/csup_sync.sv
`timescale 1ns/1ps
module csup_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = csup_pkg::SYNC_MIN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.stg[i] = sync_q.stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign dout = sync_q.stg[STAGES-1];
endmodule

// File: rtl/csup_mgr_pulse.sv
`timescale 1ns/1ps
module csup_mgr_pulse #(
    parameter int unsigned        STAT_W    = 3,
    parameter int unsigned        PULSE_LEN = 3,
    parameter logic [STAT_W-1:0]  STOP_MASK = '1
) (
    input  logic              clk,
    input  logic              ext_rst,
    input  logic              lock_s,
    input  logic [STAT_W-1:0] stat_s,
    output logic              mgr_rst_o
);
    typedef struct packed {
        logic                 lock_h;
        logic [PULSE_LEN-1:0] sr;
    } mgr_t;

    localparam mgr_t MGR_RST = '{lock_h: 1'b0, sr: '1};

    mgr_t mgr_d, mgr_q;
    logic lock_fall, stop_hit, trig;

    always_comb begin
        lock_fall    = mgr_q.lock_h & ~lock_s;
        stop_hit     = csup_pkg::any_set(32'(stat_s), 32'(STOP_MASK));
        trig         = lock_fall | stop_hit;
        mgr_d        = mgr_q;
        mgr_d.lock_h = lock_s;
        mgr_d.sr     = {trig, mgr_q.sr[PULSE_LEN-1:1]};
    end

    always_ff @(posedge clk) begin
        if (ext_rst) mgr_q <= MGR_RST;
        else         mgr_q <= mgr_d;
    end

    assign mgr_rst_o = (|mgr_q.sr) | ext_rst;

    // Lock loss seen by the synchronizer reaches the output one edge later.
    assert_lock_loss_R1: assert property (@(posedge clk) disable iff (ext_rst)
        $fell(lock_s) |=> mgr_rst_o);

    // A stopped clock flag keeps the output high on the following cycle.
    assert_stop_flag_R2: assert property (@(posedge clk) disable iff (ext_rst)
        csup_pkg::any_set(32'(stat_s), 32'(STOP_MASK)) |=> mgr_rst_o);

    // No pulse is shorter than three reference cycles.
    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (ext_rst)
        $fell(mgr_rst_o) |-> ($past(mgr_rst_o, 2) && $past(mgr_rst_o, 3)));

    // A new pulse always has an event behind it, never a timer.
    assert_no_blind_retry_R5: assert property (@(posedge clk) disable iff (ext_rst)
        $rose(mgr_rst_o) |-> $past(lock_fall || stop_hit));
endmodule

// File: rtl/csup_dom_rst.sv
`timescale 1ns/1ps
module csup_dom_rst #(
    parameter int unsigned SYNC_N   = 2,
    parameter int unsigned HOLD_CYC = 8
) (
    input  logic syn_clk,
    input  logic ext_rst,
    input  logic lock_raw,
    input  logic in_stop_raw,
    output logic dom_rst_o
);
    localparam int unsigned      CW     = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0]    HOLD_V = CW'(HOLD_CYC);

    typedef struct packed {
        logic [SYNC_N-1:0] chain;
        logic [CW-1:0]     cnt;
        logic              rst;
    } dom_t;

    localparam dom_t DOM_RST = '{chain: '0, cnt: '0, rst: 1'b1};

    dom_t dom_d, dom_q;
    logic hold, chain_ok;

    assign hold = ext_rst | ~lock_raw | in_stop_raw;

    always_comb begin
        chain_ok    = dom_q.chain[SYNC_N-1];
        dom_d       = dom_q;
        dom_d.chain = {dom_q.chain[SYNC_N-2:0], 1'b1};
        if (chain_ok && (dom_q.cnt != HOLD_V)) dom_d.cnt = dom_q.cnt + 1'b1;
        dom_d.rst   = (dom_d.cnt != HOLD_V);
    end

    always_ff @(posedge syn_clk or posedge hold) begin
        if (hold) dom_q <= DOM_RST;
        else      dom_q <= dom_d;
    end

    assign dom_rst_o = dom_q.rst;

    // Missing lock or a stopped input clock always shows as reset.
    assert_held_while_bad_R7: assert property (@(posedge syn_clk) disable iff (ext_rst)
        (!lock_raw || in_stop_raw) |-> dom_rst_o);

    // Release only happens with lock present and the input clock running.
    assert_release_clean_R8: assert property (@(posedge syn_clk) disable iff (ext_rst)
        $fell(dom_rst_o) |-> (lock_raw && !in_stop_raw));
endmodule

// File: rtl/clkmgr_rst_sup.sv
`timescale 1ns/1ps
module clkmgr_rst_sup #(
    parameter int unsigned STAT_W       = 3,
    parameter int unsigned IN_STOP_IDX  = 1,
    parameter int unsigned OUT_STOP_IDX = 2,
    parameter int unsigned PULSE_LEN    = 3,
    parameter int unsigned SYNC_N       = 2,
    parameter int unsigned HOLD_CYC     = 8
) (
    input  logic              ref_clk,
    input  logic              ext_rst,
    input  logic              lock_in,
    input  logic [STAT_W-1:0] stat_in,
    input  logic              syn_clk,
    output logic              mgr_rst,
    output logic              dom_rst
);
    localparam logic [STAT_W-1:0] STOP_MASK =
        (STAT_W'(1) << IN_STOP_IDX) | (STAT_W'(1) << OUT_STOP_IDX);
    localparam int unsigned SW = STAT_W + 1;

    logic [SW-1:0]     mon_s;
    logic              lock_s;
    logic [STAT_W-1:0] stat_s;

    csup_sync #(.W(SW), .STAGES(SYNC_N)) u_sync (
        .clk  (ref_clk),
        .rst  (ext_rst),
        .din  ({lock_in, stat_in}),
        .dout (mon_s)
    );

    assign {lock_s, stat_s} = mon_s;

    csup_mgr_pulse #(.STAT_W(STAT_W), .PULSE_LEN(PULSE_LEN), .STOP_MASK(STOP_MASK)) u_pulse (
        .clk       (ref_clk),
        .ext_rst   (ext_rst),
        .lock_s    (lock_s),
        .stat_s    (stat_s),
        .mgr_rst_o (mgr_rst)
    );

    csup_dom_rst #(.SYNC_N(SYNC_N), .HOLD_CYC(HOLD_CYC)) u_dom (
        .syn_clk     (syn_clk),
        .ext_rst     (ext_rst),
        .lock_raw    (lock_in),
        .in_stop_raw (stat_in[IN_STOP_IDX]),
        .dom_rst_o   (dom_rst)
    );
endmodule

// File: tb/sim_clkmgr_rst_sup.sv
`timescale 1ns/1ps
module sim_clkmgr_rst_sup;
    logic       ref_clk = 1'b0;
    logic       syn_clk = 1'b0;
    logic       syn_run = 1'b0;
    logic       ext_rst = 1'b0;
    logic       lock_in = 1'b1;
    logic [2:0] stat_in = 3'b000;
    logic       mgr_rst, dom_rst;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    clkmgr_rst_sup u0 (
        .ref_clk (ref_clk), .ext_rst (ext_rst), .lock_in (lock_in),
        .stat_in (stat_in), .syn_clk (syn_clk), .mgr_rst (mgr_rst), .dom_rst (dom_rst)
    );

    always #2 ref_clk = ~ref_clk;
    always begin
        #3;
        syn_clk = syn_run ? ~syn_clk : 1'b0;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic ref_step();
        @(posedge ref_clk); #1;
    endtask

    task automatic syn_step(input int n);
        repeat (n) @(posedge syn_clk);
        #1;
    endtask

    // Expected pulse after one trigger applied before edge A: edges A..F.
    function automatic logic pulse_exp(input int idx);
        return (idx >= 2 && idx <= 4);
    endfunction

    // Random model: lk[k]/st[k] = value driven before the edge k cycles back.
    function automatic logic model_trig(input logic l_new, input logic l_old, input logic [2:0] s);
        return (!l_new && l_old) || (|(s & 3'b110));
    endfunction

    initial begin
        #1 ext_rst = 1'b1;
        repeat (5) ref_step();
        chk("R4 reset holds mgr_rst", mgr_rst, 1'b1);
        chk("R7 dom_rst set without syn_clk", dom_rst, 1'b1);

        // Release with lock high; syn clock still stopped.
        @(negedge ref_clk) ext_rst = 1'b0;
        #1 chk("R4 preload after release", mgr_rst, 1'b1);
        for (int i = 0; i < 3; i++) begin
            ref_step();
            chk("R4 release tail", mgr_rst, (i < 2));
        end
        chk("R8 no release without syn_clk", dom_rst, 1'b1);
        syn_run = 1'b1;
        syn_step(9);
        chk("R8 still held at edge 9", dom_rst, 1'b1);
        syn_step(1);
        chk("R8 released at edge 10", dom_rst, 1'b0);

        // Lock loss: pulse shape and immediate downstream reset.
        repeat (4) ref_step();
        @(negedge ref_clk) lock_in = 1'b0;
        #0.5 chk("R7 dom_rst on lock loss", dom_rst, 1'b1);
        for (int i = 0; i < 6; i++) begin
            ref_step();
            chk("R1 R3 lock-loss pulse", mgr_rst, pulse_exp(i));
        end
        for (int i = 0; i < 60; i++) begin
            ref_step();
            chk("R5 no retry while unlocked", mgr_rst, 1'b0);
        end
        @(negedge ref_clk) lock_in = 1'b1;
        for (int i = 0; i < 10; i++) begin
            ref_step();
            chk("R6 lock rise quiet", mgr_rst, 1'b0);
        end

        // Downstream release count and restart.
        @(negedge syn_clk) lock_in = 1'b0;
        syn_step(3);
        chk("R7 held while unlocked", dom_rst, 1'b1);
        @(negedge syn_clk) lock_in = 1'b1;
        syn_step(5);
        chk("R9 held mid-count", dom_rst, 1'b1);
        @(negedge syn_clk) lock_in = 1'b0;
        #0.3 chk("R9 immediate reassert", dom_rst, 1'b1);
        @(negedge syn_clk) lock_in = 1'b1;
        syn_step(9);
        chk("R9 restarted count edge 9", dom_rst, 1'b1);
        syn_step(1);
        chk("R9 restarted count edge 10", dom_rst, 1'b0);

        // Input clock stopped flag for one cycle.
        repeat (10) ref_step();
        @(negedge ref_clk) stat_in = 3'b010;
        #0.5 chk("R7 dom_rst on input stop", dom_rst, 1'b1);
        ref_step();
        chk("R2 in-stop pulse", mgr_rst, 1'b0);
        @(negedge ref_clk) stat_in = 3'b000;
        for (int i = 1; i < 6; i++) begin
            ref_step();
            chk("R2 R3 in-stop pulse", mgr_rst, pulse_exp(i));
        end
        // Output clock stopped flag for one cycle.
        repeat (4) ref_step();
        @(negedge ref_clk) stat_in = 3'b100;
        ref_step();
        chk("R2 out-stop pulse", mgr_rst, 1'b0);
        @(negedge ref_clk) stat_in = 3'b000;
        for (int i = 1; i < 6; i++) begin
            ref_step();
            chk("R2 R3 out-stop pulse", mgr_rst, pulse_exp(i));
        end

        // Held output-stop flag: mgr_rst steady high, dom_rst untouched.
        syn_step(12);
        chk("R10 dom released before", dom_rst, 1'b0);
        @(negedge syn_clk) stat_in = 3'b100;
        for (int i = 0; i < 12; i++) begin
            syn_step(1);
            chk("R10 out-stop ignored downstream", dom_rst, 1'b0);
        end
        chk("R2 held flag keeps mgr_rst", mgr_rst, 1'b1);
        @(negedge ref_clk) stat_in = 3'b000;
        repeat (6) ref_step();
        chk("R2 held flag cleared", mgr_rst, 1'b0);

        // Bit 0 is not a trigger.
        @(negedge ref_clk) stat_in = 3'b001;
        for (int i = 0; i < 10; i++) begin
            ref_step();
            chk("R11 bit0 ignored mgr", mgr_rst, 1'b0);
        end
        chk("R11 bit0 ignored dom", dom_rst, 1'b0);
        @(negedge ref_clk) stat_in = 3'b000;

        // External reset mid-run, lock low at release.
        repeat (4) ref_step();
        @(negedge ref_clk) ext_rst = 1'b1;
        #1 chk("R4 same-step mgr_rst", mgr_rst, 1'b1);
        chk("R7 same-step dom_rst", dom_rst, 1'b1);
        @(negedge ref_clk) lock_in = 1'b0;
        repeat (4) ref_step();
        @(negedge ref_clk) ext_rst = 1'b0;
        for (int i = 0; i < 14; i++) begin
            ref_step();
            chk("R4 no spurious pulse at release", mgr_rst, (i < 2));
        end
        @(negedge ref_clk) lock_in = 1'b1;
        repeat (10) ref_step();

        // Random lock/status traffic against the cycle model.
        begin
            logic       lk [6];
            logic [2:0] st [6];
            logic       exp_v;
            void'($urandom(32'd20240611));
            for (int k = 0; k < 6; k++) begin
                lk[k] = 1'b1;
                st[k] = 3'b000;
            end
            for (int n = 0; n < 3000; n++) begin
                @(negedge ref_clk);
                if (($urandom % 8) == 0) lock_in = ~lock_in;
                stat_in = (($urandom % 10) == 0) ? 3'($urandom) : 3'b000;
                for (int k = 5; k > 0; k--) begin
                    lk[k] = lk[k-1];
                    st[k] = st[k-1];
                end
                lk[0] = lock_in;
                st[0] = stat_in;
                ref_step();
                exp_v = model_trig(lk[2], lk[3], st[2]) ||
                        model_trig(lk[3], lk[4], st[3]) ||
                        model_trig(lk[4], lk[5], st[4]);
                chk("R1 R2 R3 random traffic", mgr_rst, exp_v);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule